// File: doc/BRIEF.md
# External Word Transfer Controller

This block brings words from an outside source into a processor's memories under one of three transfer disciplines, chosen by a mode select. In block mode, a start command with an address and a word count moves the words straight into data memory, one per core clock, and holds the core stalled until the batch is in. In handshake mode, words arrive at irregular times and each is taken under a request/acknowledge exchange. In merge mode, words are taken at a regular strobe that runs slower than the core clock.

Handshake and merge words go to a separate host-interface buffer memory, and the core keeps running while they arrive. The buffer write pointer wraps at a parameterized depth. An occupancy count, lowered by the consumer's pop input, guards unread words. A word that would overwrite an unread entry is dropped, and a sticky overflow flag is raised. The mode can only change while no transfer is in flight.

Top module: `ext_xfer_if`

## Requirements
- R1: In block mode (mode code 0), `blk_start` sampled high at a clock edge, with `blk_count` = N > 0, starts a batch. On each of the next N edges, `ext_data` is sampled. One cycle after each sampling edge, `dmem_we` is high with `dmem_addr` = `blk_addr` + k (modulo 2^DAW, where k counts from 0) and `dmem_wdata` = the sampled word. A start seen during a batch is ignored.
- R2: `core_stall` rises in the cycle after the accepted start. It stays high for exactly N cycles and falls in the cycle that presents the last data-memory write. It is never high outside block mode.
- R3: `blk_done` is a one-cycle pulse in the same cycle as the last data-memory write. With N = 0, `blk_done` pulses in the cycle after the start, with no write and no stall.
- R4: In handshake mode (code 1), with `ext_ack` low, an edge that samples `ext_req` and `ext_valid` both high captures `ext_data`. `ext_ack` is raised in the next cycle and held until an edge samples `ext_req` low. A request without valid data captures nothing.
- R5: In merge mode (code 2), a word is captured at the first edge that samples `ext_strobe` high after it was sampled low. A strobe that stays high captures only once.
- R6: Each captured handshake or merge word is written to the buffer in the cycle after capture, at `buf_addr` = write pointer. The pointer starts at 0, counts up by one per stored word and wraps from BUF_DEPTH-1 to 0. These modes never raise `core_stall` or `dmem_we`. Strobes and requests in a mode other than their own have no effect.
- R7: The occupancy count rises by one for each stored word. It falls by one on each edge where `buf_pop` is high and the count is non-zero. A capture at an edge where the count equals BUF_DEPTH is dropped with no buffer write and sets `overflow`. The flag stays set until reset.
- R8: `mode_now` loads `mode_sel` at an edge only when idle. Idle means no batch is in flight, `ext_ack` is low, and no start or request is accepted at that edge. Code 3 is ignored.
- R9: After reset, every output is 0 and `mode_now` is 0 (block mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested mode: 0 block, 1 handshake, 2 merge |
| blk_start | input | 1 | Start a block batch |
| blk_addr | input | DAW | First data-memory address of the batch |
| blk_count | input | CW | Number of words in the batch |
| ext_data | input | DW | External data word |
| ext_valid | input | 1 | Data valid with a handshake request |
| ext_req | input | 1 | Handshake request |
| ext_strobe | input | 1 | Slow merge-mode strobe |
| buf_pop | input | 1 | Consumer has read one buffer word |
| ext_ack | output | 1 | Handshake acknowledge |
| core_stall | output | 1 | Holds the core during a block batch |
| blk_done | output | 1 | Batch-complete pulse |
| dmem_we | output | 1 | Data-memory write enable |
| dmem_addr | output | DAW | Data-memory write address |
| dmem_wdata | output | DW | Data-memory write data |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | BAW | Buffer write address |
| buf_wdata | output | DW | Buffer write data |
| overflow | output | 1 | Sticky buffer overflow flag |
| mode_now | output | 2 | Mode in force |

## Verification
The bench drives several corner cases:
- A mode request raised mid-batch and while the acknowledge is held. A controller that switched there would misroute the rest of the batch or stall in the wrong mode.
- A zero-length batch. A wrong design would stall or write a stray word.
- A second start during a batch. A wrong design would restart the address.
- A batch crossing the top of data memory, and strobes held high for several cycles. A wrong edge detector would capture duplicates.
- Filling the buffer past its depth and then draining it, so that a wrong wrap or full test shows up as a clobbered address, a missing overflow or a refused word after pops.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    MODE_BLOCK = 2'd0,
    MODE_HSHK  = 2'd1,
    MODE_MERGE = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/blk_xfer_unit.sv
module blk_xfer_unit #(
  parameter int DW  = 16,
  parameter int DAW = 10,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [DAW-1:0] start_addr,
  input  logic [CW-1:0]  count,
  input  logic [DW-1:0]  din,
  output logic           busy,
  output logic           we,
  output logic [DAW-1:0] addr,
  output logic [DW-1:0]  wdata,
  output logic           done
);
  logic [DAW-1:0] ptr;
  logic [CW-1:0]  rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ptr   <= '0;
      rem   <= '0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
      done  <= 1'b0;
    end else begin
      we   <= 1'b0;
      done <= 1'b0;
      if (busy) begin
        we    <= 1'b1;
        addr  <= ptr;
        wdata <= din;
        ptr   <= ptr + 1'b1;
        rem   <= rem - 1'b1;
        if (rem == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (go) begin
        if (count == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          ptr  <= start_addr;
          rem  <= count;
        end
      end
    end
  end

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_write_follows_busy_R1: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(busy));
endmodule

// File: rtl/hs_capture.sv
module hs_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          req,
  input  logic          valid,
  input  logic [DW-1:0] din,
  output logic          ack,
  output logic          cap,
  output logic [DW-1:0] cap_data
);
  assign cap      = en && !ack && req && valid;
  assign cap_data = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
    end else if (ack) begin
      if (!req) ack <= 1'b0;
    end else if (cap) begin
      ack <= 1'b1;
    end
  end

  assert_ack_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack);
  assert_ack_after_valid_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(req && valid));
endmodule

// File: rtl/merge_capture.sv
module merge_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic          cap,
  output logic [DW-1:0] cap_data
);
  logic strobe_q;

  assign cap      = en && strobe && !strobe_q;
  assign cap_data = din;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assert_single_capture_R5: assert property (@(posedge clk) disable iff (rst)
    cap |=> !cap);
endmodule

// File: rtl/hib_writer.sv
module hib_writer #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          pop,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          overflow
);
  localparam int OCW = $clog2(DEPTH + 1);
  localparam logic [OCW-1:0] FULL = OCW'(DEPTH);
  localparam logic [AW-1:0]  LAST = AW'(DEPTH - 1);

  logic [AW-1:0]  wptr;
  logic [OCW-1:0] occ;
  logic           accept;
  logic           drain;

  assign accept = cap && (occ != FULL);
  assign drain  = pop && (occ != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      occ      <= '0;
      we       <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
      overflow <= 1'b0;
    end else begin
      we <= accept;
      if (accept) begin
        addr  <= wptr;
        wdata <= cap_data;
        wptr  <= (wptr == LAST) ? '0 : wptr + 1'b1;
      end
      if (cap && !accept) overflow <= 1'b1;
      case ({accept, drain})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assert_no_overflow_write_R7: assert property (@(posedge clk) disable iff (rst)
    (occ == FULL) |=> !we);
  assert_ptr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    wptr <= LAST);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: rtl/ext_xfer_if.sv
module ext_xfer_if #(
  parameter int DW        = 16,
  parameter int DAW       = 10,
  parameter int CW        = 8,
  parameter int BUF_DEPTH = 8,
  parameter int BAW       = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode_sel,
  input  logic           blk_start,
  input  logic [DAW-1:0] blk_addr,
  input  logic [CW-1:0]  blk_count,
  input  logic [DW-1:0]  ext_data,
  input  logic           ext_valid,
  input  logic           ext_req,
  input  logic           ext_strobe,
  input  logic           buf_pop,
  output logic           ext_ack,
  output logic           core_stall,
  output logic           blk_done,
  output logic           dmem_we,
  output logic [DAW-1:0] dmem_addr,
  output logic [DW-1:0]  dmem_wdata,
  output logic           buf_we,
  output logic [BAW-1:0] buf_addr,
  output logic [DW-1:0]  buf_wdata,
  output logic           overflow,
  output logic [1:0]     mode_now
);
  import xfer_pkg::*;

  xfer_mode_e    mode_q;
  logic          blk_go, blk_busy;
  logic          hs_en, hs_cap;
  logic          mg_en, mg_cap;
  logic [DW-1:0] hs_data, mg_data;
  logic          any_cap;
  logic [DW-1:0] any_data;
  logic          idle;

  assign blk_go = (mode_q == MODE_BLOCK) && blk_start;
  assign hs_en  = (mode_q == MODE_HSHK);
  assign mg_en  = (mode_q == MODE_MERGE);
  assign idle   = !blk_busy && !ext_ack && !blk_go && !hs_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_BLOCK;
    end else if (idle && (mode_sel != 2'd3)) begin
      mode_q <= xfer_mode_e'(mode_sel);
    end
  end

  assign mode_now   = mode_q;
  assign core_stall = blk_busy;

  blk_xfer_unit #(.DW(DW), .DAW(DAW), .CW(CW)) blk_u (
    .clk(clk), .rst(rst), .go(blk_go), .start_addr(blk_addr),
    .count(blk_count), .din(ext_data), .busy(blk_busy),
    .we(dmem_we), .addr(dmem_addr), .wdata(dmem_wdata), .done(blk_done)
  );

  hs_capture #(.DW(DW)) hs_u (
    .clk(clk), .rst(rst), .en(hs_en), .req(ext_req), .valid(ext_valid),
    .din(ext_data), .ack(ext_ack), .cap(hs_cap), .cap_data(hs_data)
  );

  merge_capture #(.DW(DW)) mg_u (
    .clk(clk), .rst(rst), .en(mg_en), .strobe(ext_strobe),
    .din(ext_data), .cap(mg_cap), .cap_data(mg_data)
  );

  assign any_cap  = hs_cap | mg_cap;
  assign any_data = hs_cap ? hs_data : mg_data;

  hib_writer #(.DW(DW), .DEPTH(BUF_DEPTH), .AW(BAW)) buf_u (
    .clk(clk), .rst(rst), .cap(any_cap), .cap_data(any_data),
    .pop(buf_pop), .we(buf_we), .addr(buf_addr), .wdata(buf_wdata),
    .overflow(overflow)
  );

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (core_stall || ext_ack) |=> $stable(mode_now));
  assert_stall_block_only_R2: assert property (@(posedge clk) disable iff (rst)
    core_stall |-> (mode_now == 2'd0));
  assert_one_target_R6: assert property (@(posedge clk) disable iff (rst)
    !(buf_we && dmem_we));
endmodule

// File: tb/ext_xfer_if_tb.sv
module ext_xfer_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, DAW = 10, CW = 8, DEPTH = 8, BAW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic blk_start = 1'b0;
  logic [DAW-1:0] blk_addr = '0;
  logic [CW-1:0] blk_count = '0;
  logic [DW-1:0] ext_data = '0;
  logic ext_valid = 1'b0, ext_req = 1'b0, ext_strobe = 1'b0, buf_pop = 1'b0;
  logic ext_ack, core_stall, blk_done, dmem_we, buf_we, overflow;
  logic [DAW-1:0] dmem_addr;
  logic [DW-1:0] dmem_wdata, buf_wdata;
  logic [BAW-1:0] buf_addr;
  logic [1:0] mode_now;

  int nchk = 0, nfail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_xfer_if #(.DW(DW), .DAW(DAW), .CW(CW), .BUF_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .blk_start(blk_start),
    .blk_addr(blk_addr), .blk_count(blk_count), .ext_data(ext_data),
    .ext_valid(ext_valid), .ext_req(ext_req), .ext_strobe(ext_strobe),
    .buf_pop(buf_pop), .ext_ack(ext_ack), .core_stall(core_stall),
    .blk_done(blk_done), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .overflow(overflow), .mode_now(mode_now)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model state
  int m_mode, m_rem, m_ptr, m_addr, m_data, m_baddr, m_bdata, m_wptr;
  bit m_busy, m_we, m_done, m_ack, m_stq, m_bwe, m_ovf;
  int unread[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_mode = 0; m_rem = 0; m_ptr = 0; m_addr = 0; m_data = 0;
      m_baddr = 0; m_bdata = 0; m_wptr = 0;
      m_busy = 0; m_we = 0; m_done = 0; m_ack = 0; m_stq = 0; m_bwe = 0; m_ovf = 0;
      unread.delete();
    end else begin
      bit go_b, go_h, cap, idle;
      int cd, fill;
      go_b = (m_mode == 0) && blk_start;
      go_h = (m_mode == 1) && !m_ack && ext_req && ext_valid;
      idle = !m_busy && !m_ack && !go_b && !go_h;
      cap = 0; cd = 0;
      m_we = 0; m_done = 0;
      if (m_busy) begin
        m_we = 1; m_addr = m_ptr; m_data = ext_data;
        m_ptr = (m_ptr + 1) % (1 << DAW);
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; end
      end else if (go_b) begin
        if (blk_count == 0) m_done = 1;
        else begin m_busy = 1; m_ptr = blk_addr; m_rem = blk_count; end
      end
      if (m_ack) begin
        if (!ext_req) m_ack = 0;
      end else if (go_h) begin
        m_ack = 1; cap = 1; cd = ext_data;
      end
      if (m_mode == 2 && ext_strobe && !m_stq) begin cap = 1; cd = ext_data; end
      m_stq = ext_strobe;
      fill = unread.size();
      m_bwe = 0;
      if (cap) begin
        if (fill < DEPTH) begin
          unread.push_back(cd);
          m_bwe = 1; m_baddr = m_wptr; m_bdata = cd;
          m_wptr = (m_wptr + 1) % DEPTH;
        end else m_ovf = 1;
      end
      if (buf_pop && fill > 0) void'(unread.pop_front());
      if (idle && mode_sel != 2'd3) m_mode = mode_sel;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 dmem_we", dmem_we, m_we);
      if (m_we) begin
        chk("R1 dmem_addr", dmem_addr, m_addr);
        chk("R1 dmem_wdata", dmem_wdata, m_data);
      end
      chk("R2 core_stall", core_stall, m_busy);
      chk("R3 blk_done", blk_done, m_done);
      chk("R4 ext_ack", ext_ack, m_ack);
      if (m_mode == 2) chk("R5 buf_we merge", buf_we, m_bwe);
      else             chk("R6 buf_we", buf_we, m_bwe);
      if (m_bwe) begin
        chk("R6 buf_addr", buf_addr, m_baddr);
        chk("R6 buf_wdata", buf_wdata, m_bdata);
      end
      chk("R7 overflow", overflow, m_ovf);
      chk("R8 mode_now", mode_now, m_mode);
    end
  end

  // Data source: a new word every cycle
  always @(negedge clk) ext_data <= ext_data + 16'd37;

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic block_go(input int a, input int n);
    @(negedge clk);
    blk_addr = DAW'(a); blk_count = CW'(n); blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
  endtask

  task automatic hs_word(input int gap, input int hold);
    cycles(gap);
    ext_req = 1'b1; ext_valid = 1'b1;
    for (int i = 0; i < 20 && !ext_ack; i++) @(negedge clk);
    ext_valid = 1'b0;
    cycles(hold);
    ext_req = 1'b0;
    cycles(1);
  endtask

  task automatic strobe_words(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ext_strobe = 1'b1; cycles(hi);
      ext_strobe = 1'b0; cycles(lo);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  initial begin
    cycles(3);
    // R9: reset values
    chk("R9 stall", core_stall, 0); chk("R9 ack", ext_ack, 0);
    chk("R9 dmem_we", dmem_we, 0);  chk("R9 buf_we", buf_we, 0);
    chk("R9 overflow", overflow, 0); chk("R9 mode", mode_now, 0);
    chk("R9 done", blk_done, 0);
    rst = 1'b0;
    cycles(2);
    // R1/R2/R3: batch of five, mode change requested mid-batch (R8)
    block_go(100, 5);
    mode_sel = 2'd2;
    cycles(3);
    chk("R8 mode held during batch", mode_now, 0);
    mode_sel = 2'd0;
    cycles(4);
    // second start during batch is ignored (R1)
    block_go(200, 3);
    blk_addr = 10'd500; blk_count = 8'd2; blk_start = 1'b1;
    cycles(1); blk_start = 1'b0;
    cycles(5);
    // wrap at top of memory, single word, zero length (R3)
    block_go(1022, 4); cycles(6);
    block_go(7, 1);    cycles(3);
    block_go(9, 0);    cycles(3);
    chk("R3 zero length no stall", core_stall, 0);
    // code 3 ignored (R8)
    mode_sel = 2'd3; cycles(2);
    chk("R8 code 3 ignored", mode_now, 0);
    // strobe in block mode ignored (R6)
    strobe_words(2, 2, 2);
    // Handshake (R4)
    mode_sel = 2'd1; cycles(2);
    chk("R8 mode to handshake", mode_now, 1);
    ext_req = 1'b1; cycles(3); ext_req = 1'b0; cycles(1); // request without valid
    for (int i = 0; i < 5; i++) hs_word(i, i % 3);
    ext_req = 1'b1; ext_valid = 1'b1; cycles(2);
    mode_sel = 2'd2; ext_valid = 1'b0; cycles(3);
    chk("R8 mode held while ack", mode_now, 1);
    ext_req = 1'b0; cycles(2);
    chk("R8 mode after ack falls", mode_now, 2);
    // Merge (R5): long-high strobes, overflow, drain, wrap
    strobe_words(4, 3, 3);
    blk_start = 1'b1; cycles(1); blk_start = 1'b0;   // ignored in merge
    strobe_words(6, 1, 4);
    chk("R7 overflow after fill", overflow, 1);
    for (int i = 0; i < 4; i++) begin buf_pop = 1'b1; cycles(1); buf_pop = 1'b0; cycles(1); end
    strobe_words(5, 2, 2);
    buf_pop = 1'b1; cycles(10); buf_pop = 1'b0;
    strobe_words(3, 4, 1);
    cycles(4);
    finish_run();
  end
endmodule